// File: doc/BRIEF.md
# Three-Level Space-Vector Dwell Calculator

This block turns a voltage reference, given as signed alpha/beta components, into the switch duty values of a three-level neutral-clamped inverter leg set. It runs once per switching period. It picks one of six main sectors around the reference and subtracts that sector's offset vector, which scales with the measured DC-link voltage. The remaining small vector is then solved as an ordinary two-level space-vector problem. The per-phase duties come from the spread of the three phase projections. The zero-vector time is shared between the two redundant small vectors in proportion to the upper half-link voltage, which steers the neutral point.

A one-cycle `start` pulse captures the inputs. Four serial dividers then work in lockstep, and a one-cycle `done` strobe marks new `sector`, `d1`, `d2` and `d3` values. These outputs hold until the next strobe. Duties are unsigned fractions with `F` fractional bits, so full scale (`2^F`) means the whole period. `d1`, `d2` and `d3` belong to phases u, v and w of the downsized two-level problem. Each duty is the on-time of the pair that selects the upper of the two levels that phase uses in the active sector.

Top module: `svm3_dwell`

## Requirements
- R1: With y = floor(beta*7094/4096), the scores 2a, a+y, y-a, -2a, -a-y and a-y (a = alpha) belong to sectors 1..6 in that order. `sector` is the index of the largest score, and a tie goes to the lower index, so a zero reference gives sector 1.
- R2: Before solving, the reference is shifted by the sector offset. Written as (6*alpha offset, 6*y offset) in multiples of vdc, the offsets are: sector 1 (2,0), sector 2 (1,3), sector 3 (-1,3), sector 4 (-2,0), sector 5 (-1,-3), sector 6 (1,-3).
- R3: With shifted values a6 and y6, the phase terms are U=2*a6, V=y6-a6 and W=-a6-y6. Each phase quotient is q = floor((X-min)*2^F/(6*vdc)). Each duty is q plus the share t of the zero time that goes to the all-upper state, and no duty exceeds 2^F.
- R4: qh = floor(vhi*2^F/vdc), where vhi = vdc - vlow. The zero share is t = floor((2^F - qmax)*qh/2^F), where qmax is the largest phase quotient.
- R5: When the phase span max-min exceeds 6*vdc, the span replaces 6*vdc as the divisor. The largest phase then gets 2^F, the smallest gets 0, and t is 0.
- R6: When vlow is at or above vdc, vhi is 0, so the smallest phase duty is 0.
- R7: `done` is high for exactly one cycle, right after the (F+3)-th rising edge that follows the edge which accepted `start`.
- R8: A `start` that arrives while a calculation is running is ignored. It does not change that result and produces no extra `done`.
- R9: During and after reset, `done`, `sector`, `d1`, `d2` and `d3` are 0. Outputs change only on the cycle `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches one calculation when idle |
| alpha | input | IW | Reference alpha component, signed |
| beta | input | IW | Reference beta component, signed |
| vdc | input | VW | Full DC-link voltage, unsigned |
| vlow | input | VW | Lower half-link voltage, unsigned |
| done | output | 1 | One-cycle result strobe |
| sector | output | 3 | Main sector 1..6 |
| d1 | output | F+1 | Phase u duty, 2^F is full period |
| d2 | output | F+1 | Phase v duty |
| d3 | output | F+1 | Phase w duty |

## Verification
A wrong sector choice or a wrong offset shows up at once, in the same `done` cycle. It appears as a wrong `sector` or as duties that no longer put the smallest phase at the zero share. A divider that slips a cycle moves `done` away from cycle F+3 or corrupts the low quotient bits. An error in the neutral-point share moves all three duties by the same amount, and that is visible as soon as `vlow` departs from half of `vdc`. A control state that fails to return to idle shows as a missing strobe on the next request, or as a second strobe caused by a `start` that should have been ignored.

// File: rtl/svm3_pkg.sv
package svm3_pkg;
    // sqrt(3) in fixed point for the beta projection
    localparam int SQ3_K  = 7094;
    localparam int SQ3_SH = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAP  = 2'd1,
        ST_DIV  = 2'd2
    } phase_e;
endpackage

// File: rtl/svm3_geom.sv
module svm3_geom
    import svm3_pkg::*;
#(
    parameter int IW = 16,
    parameter int VW = 16,
    parameter int NW = 24
) (
    input  logic signed [IW-1:0] alpha,
    input  logic signed [IW-1:0] beta,
    input  logic [VW-1:0]        vdc,
    input  logic [VW-1:0]        vlow,
    output logic [2:0]           sector,
    output logic [2:0][NW-1:0]   ph_num,
    output logic [NW-1:0]        ph_den,
    output logic [NW-1:0]        hi_num,
    output logic [NW-1:0]        hi_den
);
    localparam int PW = IW + 15;
    localparam logic signed [PW-1:0] KSQ = PW'(SQ3_K);

    logic signed [PW-1:0] b_ext, prod, y_full;
    logic signed [NW-1:0] aw, yw, vd, vd2, vd3, six_vd;
    logic signed [NW-1:0] score [6];
    logic signed [NW-1:0] best, ox, oy, a6, y6, span, mn, mx;
    logic signed [NW-1:0] ph [3];
    logic [2:0]           idx;

    always_comb begin
        b_ext  = PW'(beta);
        prod   = b_ext * KSQ;
        y_full = prod >>> SQ3_SH;
        aw     = NW'(alpha);
        yw     = NW'(y_full);
        vd     = $signed(NW'(vdc));
        vd2    = vd <<< 1;
        vd3    = vd + vd2;
        six_vd = vd2 + (vd <<< 2);

        score[0] = aw <<< 1;
        score[1] = aw + yw;
        score[2] = yw - aw;
        score[3] = -(aw <<< 1);
        score[4] = -aw - yw;
        score[5] = aw - yw;
        best = score[0];
        idx  = 3'd0;
        for (int k = 1; k < 6; k++) begin
            if (score[k] > best) begin
                best = score[k];
                idx  = 3'(k);
            end
        end

        case (idx)
            3'd0:    begin ox = vd2; oy = '0;   end
            3'd1:    begin ox = vd;  oy = vd3;  end
            3'd2:    begin ox = -vd; oy = vd3;  end
            3'd3:    begin ox = -vd2; oy = '0;  end
            3'd4:    begin ox = -vd; oy = -vd3; end
            default: begin ox = vd;  oy = -vd3; end
        endcase

        a6 = (aw <<< 2) + (aw <<< 1) - ox;
        y6 = (yw <<< 2) + (yw <<< 1) - oy;
        ph[0] = a6 <<< 1;
        ph[1] = y6 - a6;
        ph[2] = -a6 - y6;

        mn = ph[0];
        mx = ph[0];
        for (int k = 1; k < 3; k++) begin
            if (ph[k] < mn) mn = ph[k];
            if (ph[k] > mx) mx = ph[k];
        end
        span = mx - mn;
        for (int k = 0; k < 3; k++) ph_num[k] = ph[k] - mn;
        ph_den = (span > six_vd) ? span : six_vd;

        hi_den = NW'(vdc);
        hi_num = (vlow >= vdc) ? '0 : NW'(vdc - vlow);
        sector = idx + 3'd1;
    end
endmodule

// File: rtl/svm3_div.sv
module svm3_div #(
    parameter int NW = 24,
    parameter int F  = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic          fin,
    output logic [F:0]    quo
);
    localparam int CW = $clog2(F + 2);

    typedef struct packed {
        logic [NW:0]   rem;
        logic [NW-1:0] den;
        logic [F:0]    q;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          fin;
    } div_t;

    div_t r_q, r_d;
    logic          ge;
    logic [NW:0]   diff;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        ge      = 1'b0;
        diff    = r_q.rem;
        if (go) begin
            r_d.rem  = {1'b0, num};
            r_d.den  = den;
            r_d.q    = '0;
            r_d.cnt  = CW'(F + 1);
            r_d.busy = 1'b1;
        end else if (r_q.busy) begin
            ge       = (r_q.den != '0) && (r_q.rem >= {1'b0, r_q.den});
            diff     = ge ? (r_q.rem - {1'b0, r_q.den}) : r_q.rem;
            r_d.rem  = {diff[NW-1:0], 1'b0};
            r_d.q    = {r_q.q[F-1:0], ge};
            r_d.cnt  = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign fin = r_q.fin;
    assign quo = r_q.q;
endmodule

// File: rtl/svm3_dwell.sv
module svm3_dwell
    import svm3_pkg::*;
#(
    parameter int IW = 16,
    parameter int VW = 16,
    parameter int F  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [IW-1:0] alpha,
    input  logic signed [IW-1:0] beta,
    input  logic [VW-1:0]        vdc,
    input  logic [VW-1:0]        vlow,
    output logic                 done,
    output logic [2:0]           sector,
    output logic [F:0]           d1,
    output logic [F:0]           d2,
    output logic [F:0]           d3
);
    localparam int NW = ((IW > VW) ? IW : VW) + 8;
    localparam logic [F:0] ONE = (F + 1)'(1) << F;

    typedef struct packed {
        phase_e                ph;
        logic signed [IW-1:0]  alpha;
        logic signed [IW-1:0]  beta;
        logic [VW-1:0]         vdc;
        logic [VW-1:0]         vlow;
        logic [2:0]            sector;
        logic [2:0][F:0]       duty;
        logic                  done;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [2:0]          g_sector;
    logic [2:0][NW-1:0]  g_num;
    logic [NW-1:0]       g_den, g_hnum, g_hden;
    logic                go;
    logic [3:0]          fin_v;
    logic [3:0][F:0]     quo_v;
    logic [3:0][NW-1:0]  num_v, den_v;

    logic [F:0]          qmax, share;
    logic [2*F+1:0]      prod;
    logic [F+1:0]        sum;

    svm3_geom #(.IW(IW), .VW(VW), .NW(NW)) u_geom (
        .alpha (r_q.alpha),
        .beta  (r_q.beta),
        .vdc   (r_q.vdc),
        .vlow  (r_q.vlow),
        .sector(g_sector),
        .ph_num(g_num),
        .ph_den(g_den),
        .hi_num(g_hnum),
        .hi_den(g_hden)
    );

    for (genvar g = 0; g < 4; g++) begin : g_div
        if (g < 3) begin : g_phase
            assign num_v[g] = g_num[g];
            assign den_v[g] = g_den;
        end else begin : g_half
            assign num_v[g] = g_hnum;
            assign den_v[g] = g_hden;
        end
        svm3_div #(.NW(NW), .F(F)) u_div (
            .clk(clk),
            .rst(rst),
            .go (go),
            .num(num_v[g]),
            .den(den_v[g]),
            .fin(fin_v[g]),
            .quo(quo_v[g])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        go       = 1'b0;

        qmax = quo_v[0];
        for (int k = 1; k < 3; k++) begin
            if (quo_v[k] > qmax) qmax = quo_v[k];
        end
        prod  = (ONE - qmax) * quo_v[3];
        share = prod[2*F:F];

        case (r_q.ph)
            ST_IDLE: begin
                if (start) begin
                    r_d.alpha = alpha;
                    r_d.beta  = beta;
                    r_d.vdc   = vdc;
                    r_d.vlow  = vlow;
                    r_d.ph    = ST_MAP;
                end
            end
            ST_MAP: begin
                go     = 1'b1;
                r_d.ph = ST_DIV;
            end
            default: begin
                if (&fin_v) begin
                    for (int k = 0; k < 3; k++) begin
                        sum = {1'b0, quo_v[k]} + {1'b0, share};
                        r_d.duty[k] = (sum > {1'b0, ONE}) ? ONE : sum[F:0];
                    end
                    r_d.sector = g_sector;
                    r_d.done   = 1'b1;
                    r_d.ph     = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign done   = r_q.done;
    assign sector = r_q.sector;
    assign d1     = r_q.duty[0];
    assign d2     = r_q.duty[1];
    assign d3     = r_q.duty[2];
endmodule

// File: rtl/svm3_dwell_chk.sv
module svm3_dwell_chk #(
    parameter int F = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic [2:0] sector,
    input logic [F:0] d1,
    input logic [F:0] d2,
    input logic [F:0] d3
);
    localparam logic [F:0] ONE = (F + 1)'(1) << F;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    sector_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (sector >= 3'd1 && sector <= 3'd6));

    // R3
    duty_limit_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (d1 <= ONE && d2 <= ONE && d3 <= ONE));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(sector) && $stable(d1) && $stable(d2) && $stable(d3)));
endmodule

bind svm3_dwell svm3_dwell_chk #(.F(F)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .done  (done),
    .sector(sector),
    .d1    (d1),
    .d2    (d2),
    .d3    (d3)
);

// File: tb/svm3_dwell_tb.sv
`timescale 1ns/1ps
module svm3_dwell_tb;
    localparam int IW = 16;
    localparam int VW = 16;
    localparam int F  = 12;
    localparam longint ONE = 64'sd1 << F;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic signed [IW-1:0] alpha = '0;
    logic signed [IW-1:0] beta = '0;
    logic [VW-1:0]        vdc = '0;
    logic [VW-1:0]        vlow = '0;
    logic                 done;
    logic [2:0]           sector;
    logic [F:0]           d1, d2, d3;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    svm3_dwell #(.IW(IW), .VW(VW), .F(F)) u_dut (
        .clk(clk), .rst(rst), .start(start), .alpha(alpha), .beta(beta),
        .vdc(vdc), .vlow(vlow), .done(done), .sector(sector),
        .d1(d1), .d2(d2), .d3(d3)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input longint a, input longint b,
                                  input longint vd, input longint vl,
                                  output int sec, output bit ovm,
                                  output longint e1, output longint e2,
                                  output longint e3);
        longint y, sc[6], best, ox, oy, a6, y6, ph[3], mn, mx, den, q[3];
        longint vhi, qh, qmax, t, d;
        y = (b * 7094) >>> 12;
        sc[0] = 2*a; sc[1] = a + y; sc[2] = y - a;
        sc[3] = -2*a; sc[4] = -a - y; sc[5] = a - y;
        best = sc[0]; sec = 0;
        for (int k = 1; k < 6; k++) if (sc[k] > best) begin best = sc[k]; sec = k; end
        case (sec)
            0: begin ox = 2*vd; oy = 0; end
            1: begin ox = vd; oy = 3*vd; end
            2: begin ox = -vd; oy = 3*vd; end
            3: begin ox = -2*vd; oy = 0; end
            4: begin ox = -vd; oy = -3*vd; end
            default: begin ox = vd; oy = -3*vd; end
        endcase
        sec = sec + 1;
        a6 = 6*a - ox;
        y6 = 6*y - oy;
        ph[0] = 2*a6; ph[1] = y6 - a6; ph[2] = -a6 - y6;
        mn = ph[0]; mx = ph[0];
        for (int k = 1; k < 3; k++) begin
            if (ph[k] < mn) mn = ph[k];
            if (ph[k] > mx) mx = ph[k];
        end
        ovm = (mx - mn) > 6*vd;
        den = ovm ? (mx - mn) : 6*vd;
        qmax = 0;
        for (int k = 0; k < 3; k++) begin
            q[k] = (den == 0) ? 0 : ((ph[k] - mn) * ONE) / den;
            if (q[k] > qmax) qmax = q[k];
        end
        vhi = (vl >= vd) ? 0 : vd - vl;
        qh = (vd == 0) ? 0 : (vhi * ONE) / vd;
        t = ((ONE - qmax) * qh) / ONE;
        d = q[0] + t; e1 = (d > ONE) ? ONE : d;
        d = q[1] + t; e2 = (d > ONE) ? ONE : d;
        d = q[2] + t; e3 = (d > ONE) ? ONE : d;
    endfunction

    task automatic apply(input longint a, input longint b, input longint vd,
                         input longint vl, output int lat);
        @(negedge clk);
        alpha = IW'(a); beta = IW'(b); vdc = VW'(vd); vlow = VW'(vl);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!done && lat < 100);
    endtask

    task automatic run_vec(input longint a, input longint b, input longint vd,
                           input longint vl, input string req);
        int sec, lat;
        bit ovm;
        longint e1, e2, e3;
        model(a, b, vd, vl, sec, ovm, e1, e2, e3);
        apply(a, b, vd, vl, lat);
        // R7 latency
        check(lat == F + 3, "R7", "latency", lat, F + 3);
        // R1 sector decision
        check(sector == sec, "R1", "sector", sector, sec);
        // R2 R3 mapping and duty, R5 when saturated
        check(d1 == e1, ovm ? "R5" : req, "d1", d1, e1);
        check(d2 == e2, ovm ? "R5" : req, "d2", d2, e2);
        check(d3 == e3, ovm ? "R5" : req, "d3", d3, e3);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: got %0d cycles expected completion", 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int lat, cnt;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(done == 0 && sector == 0, "R9", "reset sector/done", sector, 0);
        check(d1 == 0 && d2 == 0 && d3 == 0, "R9", "reset duties", d1 + d2 + d3, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 tie: zero reference -> sector 1, state OOO
        apply(0, 0, 800, 400, lat);
        check(sector == 1, "R1", "zero-ref sector", sector, 1);
        check(d1 == 0 && d2 == ONE && d3 == ONE, "R3", "zero-ref d1", d1, 0);
        // R1 negative alpha axis -> sector 4
        apply(-100, 0, 800, 400, lat);
        check(sector == 4, "R1", "neg-alpha sector", sector, 4);
        // R4 reference exactly at mapping vector: all duties equal qh
        apply(200, 0, 600, 150, lat);
        check(d1 == 3072 && d2 == 3072 && d3 == 3072, "R4", "centre share", d1, 3072);
        // R5 overmodulation
        apply(600, 0, 800, 400, lat);
        check(d1 == ONE && d2 == 0 && d3 == 0, "R5", "ovm d1", d1, ONE);
        // R6 vlow beyond vdc
        apply(150, 90, 800, 900, lat);
        check((d1 == 0) || (d2 == 0) || (d3 == 0), "R6", "min duty zero", d1 < d2 ? d1 : d2, 0);

        // R1 R2 R3 sweep over the plane
        for (int ia = -600; ia <= 600; ia += 75)
            for (int ib = -600; ib <= 600; ib += 75)
                run_vec(ia, ib, 800, 400, "R3");
        // R4 neutral-point share sweep
        for (int iv = 0; iv <= 1000; iv += 125)
            for (int ia = -300; ia <= 300; ia += 150)
                run_vec(ia, ia / 2 + 37, 800, iv, "R4");
        // R2 other link voltages
        for (int vd = 300; vd <= 1200; vd += 300)
            for (int ib = -500; ib <= 500; ib += 125)
                run_vec(ib / 3 - 20, ib, vd, vd / 2 + 5, "R2");

        // R8 start while busy is ignored
        begin
            int sec;
            bit ovm;
            longint e1, e2, e3;
            model(250, 120, 800, 380, sec, ovm, e1, e2, e3);
            @(negedge clk);
            alpha = 250; beta = 120; vdc = 800; vlow = 380; start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            alpha = -400; beta = -50; vdc = 500; vlow = 100; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cnt = 0;
            lat = 0;
            repeat (F + 12) begin
                @(negedge clk);
                if (done) begin
                    cnt++;
                    check(d1 == e1 && d2 == e2 && d3 == e3, "R8", "busy-start d1", d1, e1);
                end
            end
            check(cnt == 1, "R8", "done count", cnt, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule